// File: doc/BRIEF.md
# Serial Port Interrupt Status Controller

This block turns the fill counts of a serial controller's receive and transmit FIFOs, two programmable trigger levels and a set of receive error strobes into a live status word, a sticky interrupt status word and one level interrupt output. Every clock the live FIFO conditions are folded into the sticky word, so a condition that was true for a single cycle is remembered until software clears it. The error strobes (overrun, framing, parity, receive timeout) set their own sticky bits directly; the timeout bit is gated by a timeout configuration value that must be nonzero.

Software reaches the block through a single-cycle register write port and a combinational read port, both addressed by a 3-bit select. The interrupt mask has no direct write path: one select ORs bits into it, another removes bits from it. The sticky word is cleared by writing ones. The interrupt output is registered and rises or falls one clock after the masked sticky state changes. The FIFOs, baud generation and serial shifting live elsewhere and only their counts and strobes arrive here.

Top module: `uart_irq_status`

## Requirements
- R1: Live status bit 0 is high when the receive count is at or above the receive trigger level, bit 1 when the receive count is zero, bit 2 when the receive count equals the FIFO depth (64 by default).
- R2: Live status bit 3 is high when the transmit count is zero, bit 4 when it equals the FIFO depth, and bit 13 when the transmit count is at or above the transmit trigger level; all other live bits read zero.
- R3: On every clock the live bits 0 to 4 are ORed into the same sticky bit positions, and live bit 13 is ORed into sticky bit 10 (never sticky bit 13); the sticky word shows them one clock after the condition is present.
- R4: A sticky bit stays set after its condition goes away until it is cleared by a write.
- R5: A write to select 0 ORs the written data into the mask, a write to select 1 clears the written bits from the mask, and a write to select 2 leaves the mask unchanged; select 2 reads the mask.
- R6: A write to select 3 clears every sticky bit written as one and leaves the others; select 3 reads the sticky word.
- R7: The interrupt output is registered: it goes high one clock after any bit is set in both mask and sticky word, and goes low one clock after no such bit remains.
- R8: An overrun strobe sets sticky bit 5, a framing strobe bit 6, a parity strobe bit 7; a timeout strobe sets bit 8 only while the timeout configuration input is nonzero.
- R9: Reset sets both trigger levels to 32 and clears the mask, the sticky word and the interrupt output.
- R10: When an overrun strobe and a write-one-to-clear of bit 5 arrive in the same cycle, bit 5 ends set.
- R11: Select 4 reads the live status and ignores writes; selects 5 and 6 write and read the receive and transmit trigger levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 7 | Receive FIFO fill count |
| tx_count | input | 7 | Transmit FIFO fill count |
| ovr_evt | input | 1 | Receive overrun strobe |
| frame_evt | input | 1 | Framing error strobe |
| par_evt | input | 1 | Parity error strobe |
| tmo_evt | input | 1 | Receive timeout strobe |
| tmo_cfg | input | 8 | Timeout configuration; nonzero arms the timeout bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 16 | Read data for the selected register |
| irq | output | 1 | Registered level interrupt |

## Verification
The live status is driven through a table of count pairs that reach empty, full, exactly-at-trigger, one-below-trigger and mixed receive and transmit corners, which separates an off-by-one compare from a wrong bit position and shows whether the transmit trigger lands at bit 13. Sticky behaviour is tried with a transmit count over its trigger to tell the remapped bit 10 from a straight copy, with conditions that then vanish to prove persistence, and with a simultaneous overrun and clear to expose the priority. Mask tests interleave set, direct and clear writes so that a writable mask or a plain overwrite shows up, and the interrupt is sampled on both sides of each edge to tell a registered output from a combinational one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   // live status bit positions
   localparam int LS_RX_TRIG  = 0;
   localparam int LS_RX_EMPTY = 1;
   localparam int LS_RX_FULL  = 2;
   localparam int LS_TX_EMPTY = 3;
   localparam int LS_TX_FULL  = 4;
   localparam int LS_TX_TRIG  = 13;

   // number of low live bits mirrored one-to-one into the sticky word
   localparam int MIRROR_BITS = 5;

   // sticky status bit positions
   localparam int ST_OVERRUN = 5;
   localparam int ST_FRAMING = 6;
   localparam int ST_PARITY  = 7;
   localparam int ST_TIMEOUT = 8;
   localparam int ST_TX_TRIG = 10;

   localparam int MIN_WORD_W = 14;

   typedef enum logic [2:0] {
      SEL_MASK_SET = 3'd0,
      SEL_MASK_CLR = 3'd1,
      SEL_MASK     = 3'd2,
      SEL_STICKY   = 3'd3,
      SEL_LIVE     = 3'd4,
      SEL_RX_LVL   = 3'd5,
      SEL_TX_LVL   = 3'd6
   } reg_sel_e;

endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
   import uart_irq_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int CNT_W  = $clog2(DEPTH + 1),
   parameter int WORD_W = 16
) (
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic [CNT_W-1:0]  tx_level,
   output logic [WORD_W-1:0] live
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   initial begin : chk_params
      assert (WORD_W >= MIN_WORD_W) else $error("WORD_W too small for status layout");
      assert (DEPTH < (1 << CNT_W)) else $error("CNT_W cannot hold DEPTH");
   end

   always_comb begin
      live              = '0;
      live[LS_RX_TRIG]  = (rx_count >= rx_level);
      live[LS_RX_EMPTY] = (rx_count == '0);
      live[LS_RX_FULL]  = (rx_count == FULL_CNT);
      live[LS_TX_EMPTY] = (tx_count == '0);
      live[LS_TX_FULL]  = (tx_count == FULL_CNT);
      live[LS_TX_TRIG]  = (tx_count >= tx_level);
   end

endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
   import uart_irq_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [MIRROR_BITS-1:0] live_low,
   input  logic                   live_tx_trig,
   input  logic                   ovr_evt,
   input  logic                   frame_evt,
   input  logic                   par_evt,
   input  logic                   tmo_evt,
   input  logic                   tmo_armed,
   input  logic                   clr_we,
   input  logic [WORD_W-1:0]      clr_data,
   output logic [WORD_W-1:0]      sticky_q
);

   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] clr_vec;

   initial begin : chk_params
      assert (WORD_W > ST_TX_TRIG) else $error("WORD_W too small for sticky layout");
   end

   for (genvar b = 0; b < WORD_W; b++) begin : g_set
      if (b < MIRROR_BITS) begin : g_mirror
         assign set_vec[b] = live_low[b];
      end else if (b == ST_OVERRUN) begin : g_ovr
         assign set_vec[b] = ovr_evt;
      end else if (b == ST_FRAMING) begin : g_frm
         assign set_vec[b] = frame_evt;
      end else if (b == ST_PARITY) begin : g_par
         assign set_vec[b] = par_evt;
      end else if (b == ST_TIMEOUT) begin : g_tmo
         assign set_vec[b] = tmo_evt & tmo_armed;
      end else if (b == ST_TX_TRIG) begin : g_txt
         assign set_vec[b] = live_tx_trig;
      end else begin : g_none
         assign set_vec[b] = 1'b0;
      end
   end

   assign clr_vec = clr_we ? clr_data : '0;

   // set has priority over a clear of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= (sticky_q & ~clr_vec) | set_vec;
   end

   assert_sticky_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

   assert_ovr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> sticky_q[ST_OVERRUN]);

   assert_tmo_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_evt && !tmo_armed && !sticky_q[ST_TIMEOUT]) |=> !sticky_q[ST_TIMEOUT]);

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
   parameter int WORD_W         = 16,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W-1:0] sticky,
   output logic [WORD_W-1:0] mask_q,
   output logic              irq
);

   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] clr_vec;
   logic              irq_hit;

   assign set_vec = set_we ? wr_data : '0;
   assign clr_vec = clr_we ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q | set_vec) & ~clr_vec;
   end

   assign irq_hit = |(mask_q & sticky);

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_hit;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_hit;
   end

   assert_mask_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((mask_q & $past(wr_data)) == '0));

   assert_mask_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_irq_pkg::*;
#(
   parameter int DEPTH          = 64,
   parameter int CNT_W          = $clog2(DEPTH + 1),
   parameter int WORD_W         = 16,
   parameter int TMO_W          = 8,
   parameter int TRIG_RESET     = 32,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              ovr_evt,
   input  logic              frame_evt,
   input  logic              par_evt,
   input  logic              tmo_evt,
   input  logic [TMO_W-1:0]  tmo_cfg,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [2:0]        rd_sel,
   output logic [WORD_W-1:0] rd_data,
   output logic              irq
);

   localparam logic [CNT_W-1:0] LVL_RST = CNT_W'(TRIG_RESET);

   initial begin : chk_params
      assert (TRIG_RESET <= DEPTH) else $error("TRIG_RESET above DEPTH");
      assert (CNT_W <= WORD_W) else $error("CNT_W wider than WORD_W");
   end

   logic [CNT_W-1:0]  rx_lvl_q, tx_lvl_q;
   logic [WORD_W-1:0] live, sticky, mask;
   logic              we_mset, we_mclr, we_stk;

   assign we_mset = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK_SET);
   assign we_mclr = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK_CLR);
   assign we_stk  = wr_en && (reg_sel_e'(wr_sel) == SEL_STICKY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lvl_q <= LVL_RST;
         tx_lvl_q <= LVL_RST;
      end else if (wr_en) begin
         if (reg_sel_e'(wr_sel) == SEL_RX_LVL) rx_lvl_q <= wr_data[CNT_W-1:0];
         if (reg_sel_e'(wr_sel) == SEL_TX_LVL) tx_lvl_q <= wr_data[CNT_W-1:0];
      end
   end

   uart_irq_live #(.DEPTH(DEPTH), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_live (
      .rx_count (rx_count),
      .tx_count (tx_count),
      .rx_level (rx_lvl_q),
      .tx_level (tx_lvl_q),
      .live     (live)
   );

   uart_irq_sticky #(.WORD_W(WORD_W)) u_sticky (
      .clk          (clk),
      .rst_n        (rst_n),
      .live_low     (live[MIRROR_BITS-1:0]),
      .live_tx_trig (live[LS_TX_TRIG]),
      .ovr_evt      (ovr_evt),
      .frame_evt    (frame_evt),
      .par_evt      (par_evt),
      .tmo_evt      (tmo_evt),
      .tmo_armed    (|tmo_cfg),
      .clr_we       (we_stk),
      .clr_data     (wr_data),
      .sticky_q     (sticky)
   );

   uart_irq_mask #(.WORD_W(WORD_W), .IRQ_REGISTERED(IRQ_REGISTERED)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (we_mset),
      .clr_we  (we_mclr),
      .wr_data (wr_data),
      .sticky  (sticky),
      .mask_q  (mask),
      .irq     (irq)
   );

   always_comb begin
      unique case (reg_sel_e'(rd_sel))
         SEL_MASK:   rd_data = mask;
         SEL_STICKY: rd_data = sticky;
         SEL_LIVE:   rd_data = live;
         SEL_RX_LVL: rd_data = WORD_W'(rx_lvl_q);
         SEL_TX_LVL: rd_data = WORD_W'(tx_lvl_q);
         default:    rd_data = '0;
      endcase
   end

   assert_txtrig_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live[LS_TX_TRIG] |=> sticky[ST_TX_TRIG]);

   assert_rxempty_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live[LS_RX_EMPTY] |=> sticky[LS_RX_EMPTY]);

endmodule

// File: tb/uart_irq_status_tb.sv
`timescale 1ns/100ps
module uart_irq_status_tb;

   localparam int NV = 7;
   localparam int V_RX [NV] = '{0, 32, 64, 31, 1, 0, 64};
   localparam int V_TX [NV] = '{0, 0, 5, 32, 64, 33, 31};
   localparam logic [15:0] V_LIVE [NV] =
      '{16'h000A, 16'h0009, 16'h0005, 16'h2000, 16'h2010, 16'h2002, 16'h0005};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  rx_count = '0, tx_count = '0;
   logic        ovr_evt = 0, frame_evt = 0, par_evt = 0, tmo_evt = 0;
   logic [7:0]  tmo_cfg = '0;
   logic        wr_en = 0;
   logic [2:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        irq;

   int n_checks = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   uart_irq_status u_dut (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
      .ovr_evt(ovr_evt), .frame_evt(frame_evt), .par_evt(par_evt),
      .tmo_evt(tmo_evt), .tmo_cfg(tmo_cfg), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] sel, output logic [15:0] val);
      @(negedge clk);
      rd_sel = sel;
      #0.5;
      val = rd_data;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin : watchdog
      #400000;
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R9 reset state
      rd(3'd2, v); check("R9 mask reset", v, 16'h0000);
      rd(3'd3, v); check("R9 sticky reset", v, 16'h0000);
      rd(3'd5, v); check("R9 rx level reset", v, 16'd32);
      rd(3'd6, v); check("R9 tx level reset", v, 16'd32);
      check("R9 irq reset", {15'd0, irq}, 16'h0000);
      rx_count = 7'd5; tx_count = 7'd5;
      @(negedge clk); rst_n = 1'b1;
      rd(3'd3, v); check("R3 no condition no sticky", v, 16'h0000);

      // table of count pairs against live status (R1, R2)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rx_count = 7'(V_RX[i]); tx_count = 7'(V_TX[i]);
         rd_sel = 3'd4;
         #0.5;
         check($sformatf("R1/R2 live vec %0d", i), rd_data, V_LIVE[i]);
      end

      // R6 write-one-to-clear
      @(negedge clk); rx_count = 7'd5; tx_count = 7'd5;
      wr(3'd3, 16'hFFFF);
      rd(3'd3, v); check("R6 sticky cleared", v, 16'h0000);

      // R3 remap and R4 persistence
      @(negedge clk); rx_count = 7'd0; tx_count = 7'd40;
      rd(3'd3, v); check("R3 txtrig at bit 10", v, 16'h0402);
      @(negedge clk); rx_count = 7'd5; tx_count = 7'd5;
      rd(3'd3, v); check("R4 sticky persists", v, 16'h0402);
      wr(3'd3, 16'h0400);
      rd(3'd3, v); check("R6 partial clear", v, 16'h0002);
      wr(3'd3, 16'hFFFF);

      // R8 error strobes
      @(negedge clk); frame_evt = 1;
      @(negedge clk); frame_evt = 0; par_evt = 1;
      @(negedge clk); par_evt = 0; tmo_evt = 1; tmo_cfg = 8'd0;
      @(negedge clk); tmo_evt = 0;
      rd(3'd3, v); check("R8 frame parity, timeout gated", v, 16'h00C0);
      @(negedge clk); tmo_evt = 1; tmo_cfg = 8'd5;
      @(negedge clk); tmo_evt = 0;
      rd(3'd3, v); check("R8 timeout armed", v, 16'h01C0);
      wr(3'd3, 16'hFFFF);

      // R10 set wins over clear
      @(negedge clk);
      ovr_evt = 1; wr_en = 1; wr_sel = 3'd3; wr_data = 16'h0020;
      @(negedge clk); ovr_evt = 0; wr_en = 0;
      rd(3'd3, v); check("R10 overrun beats clear", v, 16'h0020);
      wr(3'd3, 16'hFFFF);

      // R5 mask
      wr(3'd0, 16'h0040); rd(3'd2, v); check("R5 enable sets", v, 16'h0040);
      wr(3'd0, 16'h0100); rd(3'd2, v); check("R5 enable ORs", v, 16'h0140);
      wr(3'd2, 16'hFFFF); rd(3'd2, v); check("R5 direct write ignored", v, 16'h0140);
      wr(3'd1, 16'h0040); rd(3'd2, v); check("R5 disable clears", v, 16'h0100);
      wr(3'd1, 16'hFFFF);
      wr(3'd0, 16'h0040);

      // R7 registered interrupt
      @(negedge clk); frame_evt = 1;
      @(negedge clk); frame_evt = 0;
      check("R7 irq not yet", {15'd0, irq}, 16'h0000);
      @(negedge clk);
      check("R7 irq rises one clock later", {15'd0, irq}, 16'h0001);
      wr(3'd3, 16'h0040);
      check("R7 irq held one clock after clear", {15'd0, irq}, 16'h0001);
      @(negedge clk);
      check("R7 irq falls", {15'd0, irq}, 16'h0000);

      // R11 levels and read-only live
      wr(3'd5, 16'd4);
      @(negedge clk); rx_count = 7'd4; tx_count = 7'd5;
      rd(3'd4, v); check("R11 rx level moves trigger", v, 16'h0001);
      wr(3'd6, 16'd5);
      rd(3'd4, v); check("R11 tx level moves trigger", v, 16'h2001);
      wr(3'd4, 16'hFFFF);
      rd(3'd4, v); check("R11 live ignores writes", v, 16'h2001);
      rd(3'd5, v); check("R11 rx level readback", v, 16'd4);

      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule